// File: doc/BRIEF.md
# DAC Sample FIFO with Swing Replay

This block sits in front of a digital-to-analog converter channel. Software writes samples through a small 32-bit register bus, and the block presents one sample at a time on `dac_code` for the converter to hold. It has three modes. In bypass mode a write goes straight to the output. In normal mode samples queue in a FIFO, and each trigger moves the read pointer on by one. In swing mode a filled FIFO is replayed forward and then backward, so a stored half-waveform produces a full back-and-forth sweep.

A trigger comes either from an external pin or from a self-clearing control bit. The external pin passes through a synchroniser and an edge detector. Status flags report overflow, underflow, nearly-empty, full and a programmable watermark. The enabled conditions drive either an interrupt line or a DMA request line. A FIFO clear and a soft reset are also available. Depth and sample width are parameters, and the depth is encoded into a read-only field so that software can discover it.

Top module: `dac_sample_fifo`

Register map (word address on `bus_addr`):
- 0 control/status:
  - bits [1:0] mode (0 bypass, 1 normal, 2 swing, 3 behaves as bypass)
  - bit 2 trigger select (0 pin, 1 software)
  - bit 3 converter enable
  - bit 4 DMA select
  - bits 5..8 enables for under/overflow, watermark, nearly-empty and full
  - bit 9 software trigger (write-only)
  - bit 10 FIFO clear (write-only)
  - bit 11 soft reset (write-only)
  - bit 16 overflow (sticky, W1C)
  - bit 17 underflow (sticky, W1C)
  - bits 18, 19 and 20 watermark, nearly-empty and full (read-only)
  - bits [26:24] depth code (read-only)
- 1 sample data (bits [DW-1:0]).
- 2 pointers: read pointer in bits [7:0], write pointer in bits [15:8].
- 3 watermark level.

## Requirements
- R1: After reset, `dac_code` is 0, `irq` and `dma_req` are low, the pointer register reads 0, the watermark reads 0, and the control register reads only the depth code in bits [26:24], which equals log2(DEPTH)-1.
- R2: In bypass mode (mode 0 or 3), a write to address 1 appears on `dac_code` on the next clock edge, with no trigger involved.
- R3: In normal mode (mode 1), a data write stores the sample at the write pointer and increments the pointer. A trigger with two or more entries stored increments the read pointer, and the sample at the new read pointer becomes `dac_code`.
- R4: In swing mode (mode 2), triggers move the read pointer forward until one entry remains. They then move it backward until the FIFO is full, and the direction then reverses again. Each step puts the entry at the new read pointer on `dac_code`.
- R5: With select 0, each rising edge on `hw_trig` gives exactly one trigger, and the software bit is ignored. With select 1, only writing control bit 9 triggers, and the pin is ignored.
- R6: A data write in normal or swing mode while DEPTH entries are stored sets overflow (bit 16). The write is dropped, and the write pointer does not change.
- R7: A trigger in normal mode with one or zero entries stored sets underflow (bit 17). The read pointer and `dac_code` stay unchanged.
- R8: Writing 1 to bit 16 or bit 17 clears that flag. Writing 0 leaves it set.
- R9: Nearly-empty (bit 19) is set when exactly one entry is stored. Full (bit 20) is set when DEPTH entries are stored. Watermark (bit 18) is set when the stored count is below the watermark level. A watermark write above DEPTH is stored as DEPTH.
- R10: The request condition is the OR of each enabled flag; the under/overflow enable covers both flags. With DMA select 0 it drives `irq`. With DMA select 1 it drives `dma_req`, and `irq` stays low.
- R11: The FIFO clear sets both pointers and the count to 0 only while the converter enable is 0. While the enable is 1, the clear is ignored.
- R12: The soft reset returns every register, flag, pointer and `dac_code` to the R1 state.
- R13: The pointer register reports the current read and write pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_trig | input | 1 | External trigger, asynchronous |
| dac_code | output | DW | Sample presented to the converter |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with DEPTH=4, DW=12 and SYNC_STAGES=2. A depth of 4 makes the full and overflow states reachable within a few writes. It also makes a complete swing cycle short: forward to one entry, back to full, and forward again. With only two pointer bits, the read and write pointers wrap several times during the run. The default width of 12 bits keeps the sample values distinct, so the scoreboard can match each change on `dac_code` against the value it predicted.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   typedef enum logic [1:0] {
      MODE_BYPASS = 2'd0,
      MODE_NORMAL = 2'd1,
      MODE_SWING  = 2'd2,
      MODE_RSVD   = 2'd3
   } dsf_mode_e;

   // register word addresses
   localparam logic [1:0] A_CTRL  = 2'd0;
   localparam logic [1:0] A_DATA  = 2'd1;
   localparam logic [1:0] A_PTR   = 2'd2;
   localparam logic [1:0] A_WMARK = 2'd3;

   // control/status bit positions
   localparam int unsigned CB_MODE  = 0;
   localparam int unsigned CB_TSEL  = 2;
   localparam int unsigned CB_CONV  = 3;
   localparam int unsigned CB_DMA   = 4;
   localparam int unsigned CB_IE    = 5;
   localparam int unsigned CB_SWTRG = 9;
   localparam int unsigned CB_FRST  = 10;
   localparam int unsigned CB_SRST  = 11;
   localparam int unsigned CB_OVF   = 16;
   localparam int unsigned CB_UDF   = 17;
   localparam int unsigned CB_WM    = 18;
   localparam int unsigned CB_NE    = 19;
   localparam int unsigned CB_FULL  = 20;
   localparam int unsigned CB_DCODE = 24;

   // interrupt-enable vector slots
   localparam int unsigned IE_UO   = 0;
   localparam int unsigned IE_WM   = 1;
   localparam int unsigned IE_NE   = 2;
   localparam int unsigned IE_FULL = 3;

endpackage

// File: rtl/dsf_trig.sv
module dsf_trig #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic hw_trig,
   input  logic sw_req,
   input  logic sel_sw,
   output logic trig_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   sw_q;
   logic                   hw_pulse;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sync_q <= '0;
            else if (srst) sync_q <= '0;
            else           sync_q <= hw_trig;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sync_q <= '0;
            else if (srst) sync_q <= '0;
            else           sync_q <= {sync_q[SYNC_STAGES-2:0], hw_trig};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         sw_q   <= 1'b0;
      end else if (srst) begin
         prev_q <= 1'b0;
         sw_q   <= 1'b0;
      end else begin
         prev_q <= sync_q[SYNC_STAGES-1];
         sw_q   <= sw_req;
      end
   end

   assign hw_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign trig_o   = sel_sw ? sw_q : hw_pulse;

endmodule

// File: rtl/dsf_store.sv
module dsf_store
   import dsf_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 12,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          fifo_clr,
   input  dsf_mode_e     mode,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          trig,
   output logic [DW-1:0] dac_code,
   output logic [AW-1:0] rd_ptr,
   output logic [AW-1:0] wr_ptr,
   output logic [CW-1:0] count,
   output logic          ovf_evt,
   output logic          udf_evt
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] ONE_CNT  = CW'(1);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] rd_q, wr_q, rd_fwd, rd_bak;
   logic [CW-1:0] cnt_q;
   logic [DW-1:0] out_q;
   logic          dir_fwd_q;

   logic fifo_mode, is_full, push, norm_trig, swing_trig;
   logic go_fwd, step_f, step_b, bypass_wr;

   always_comb begin
      fifo_mode  = (mode == MODE_NORMAL) || (mode == MODE_SWING);
      bypass_wr  = wr_en & ~fifo_mode;
      is_full    = (cnt_q == FULL_CNT);
      push       = wr_en & fifo_mode & ~is_full;
      ovf_evt    = wr_en & fifo_mode & is_full;
      norm_trig  = trig & (mode == MODE_NORMAL);
      swing_trig = trig & (mode == MODE_SWING) & (cnt_q != '0);
      udf_evt    = norm_trig & (cnt_q <= ONE_CNT);
      go_fwd     = dir_fwd_q ? (cnt_q > ONE_CNT) : is_full;
      step_f     = (norm_trig & (cnt_q > ONE_CNT)) | (swing_trig & go_fwd);
      step_b     = swing_trig & ~go_fwd;
      rd_fwd     = rd_q + AW'(1);
      rd_bak     = rd_q - AW'(1);
   end

   // sample storage carries no reset
   always_ff @(posedge clk) begin
      if (push && !srst && !fifo_clr) mem[wr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= '0;
         wr_q      <= '0;
         cnt_q     <= '0;
         out_q     <= '0;
         dir_fwd_q <= 1'b1;
      end else if (srst) begin
         rd_q      <= '0;
         wr_q      <= '0;
         cnt_q     <= '0;
         out_q     <= '0;
         dir_fwd_q <= 1'b1;
      end else if (fifo_clr) begin
         rd_q      <= '0;
         wr_q      <= '0;
         cnt_q     <= '0;
         dir_fwd_q <= 1'b1;
      end else begin
         if (push) wr_q <= wr_q + AW'(1);
         if (step_f) begin
            rd_q  <= rd_fwd;
            out_q <= mem[rd_fwd];
         end else if (step_b) begin
            rd_q  <= rd_bak;
            out_q <= mem[rd_bak];
         end
         if (bypass_wr) out_q <= wdata;
         if (swing_trig) dir_fwd_q <= go_fwd;
         case ({push, step_f, step_b})
            3'b100, 3'b001: cnt_q <= cnt_q + ONE_CNT;
            3'b010:         cnt_q <= cnt_q - ONE_CNT;
            3'b101:         cnt_q <= cnt_q + CW'(2);
            default:        cnt_q <= cnt_q;
         endcase
      end
   end

   assign dac_code = out_q;
   assign rd_ptr   = rd_q;
   assign wr_ptr   = wr_q;
   assign count    = cnt_q;

endmodule

// File: rtl/dsf_flags.sv
module dsf_flags
   import dsf_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic          ovf_evt,
   input  logic          udf_evt,
   input  logic          clr_ovf,
   input  logic          clr_udf,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] wmark,
   input  logic [3:0]    ie,
   input  logic          dma_sel,
   output logic          ovf_f,
   output logic          udf_f,
   output logic          wm_f,
   output logic          ne_f,
   output logic          full_f,
   output logic          irq,
   output logic          dma_req
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic ovf_q, udf_q, cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else if (srst) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         if (ovf_evt)      ovf_q <= 1'b1;
         else if (clr_ovf) ovf_q <= 1'b0;
         if (udf_evt)      udf_q <= 1'b1;
         else if (clr_udf) udf_q <= 1'b0;
      end
   end

   always_comb begin
      wm_f   = (count < wmark);
      ne_f   = (count == CW'(1));
      full_f = (count == FULL_CNT);
      cond   = (ie[IE_UO] & (ovf_q | udf_q)) | (ie[IE_WM] & wm_f)
             | (ie[IE_NE] & ne_f) | (ie[IE_FULL] & full_f);
   end

   assign ovf_f   = ovf_q;
   assign udf_f   = udf_q;
   assign irq     = cond & ~dma_sel;
   assign dma_req = cond & dma_sel;

endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
   import dsf_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned DW          = 12,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned CW         = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [1:0]    bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic          hw_trig,
   output logic [DW-1:0] dac_code,
   output logic          irq,
   output logic          dma_req
);

   localparam logic [2:0]    DCODE    = 3'(AW - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH > 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two from 2 to 256");
      end
      if (DW < 1 || DW > 32) begin : g_bad_width
         $error("DW must lie between 1 and 32");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   dsf_mode_e     mode_q;
   logic          tsel_q, conv_q, dma_q;
   logic [3:0]    ie_q;
   logic [CW-1:0] wmark_q;

   logic          ctrl_wr, data_wr, wm_wr;
   logic          srst_hit, fifo_clr, sw_req, trig;
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;
   logic          ovf_evt, udf_evt;
   logic          ovf_f, udf_f, wm_f, ne_f, full_f;
   logic [CW-1:0] wm_clamped;
   logic [7:0]    rd_field, wr_field;

   always_comb begin
      ctrl_wr  = bus_wr & (bus_addr == A_CTRL);
      data_wr  = bus_wr & (bus_addr == A_DATA);
      wm_wr    = bus_wr & (bus_addr == A_WMARK);
      srst_hit = ctrl_wr & bus_wdata[CB_SRST];
      fifo_clr = ctrl_wr & bus_wdata[CB_FRST] & ~conv_q & ~srst_hit;
      sw_req   = ctrl_wr & bus_wdata[CB_SWTRG] & ~srst_hit;
      wm_clamped = (bus_wdata > 32'(DEPTH)) ? FULL_CNT : bus_wdata[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_BYPASS;
         tsel_q  <= 1'b0;
         conv_q  <= 1'b0;
         dma_q   <= 1'b0;
         ie_q    <= '0;
         wmark_q <= '0;
      end else if (srst_hit) begin
         mode_q  <= MODE_BYPASS;
         tsel_q  <= 1'b0;
         conv_q  <= 1'b0;
         dma_q   <= 1'b0;
         ie_q    <= '0;
         wmark_q <= '0;
      end else begin
         if (ctrl_wr) begin
            mode_q <= dsf_mode_e'(bus_wdata[CB_MODE +: 2]);
            tsel_q <= bus_wdata[CB_TSEL];
            conv_q <= bus_wdata[CB_CONV];
            dma_q  <= bus_wdata[CB_DMA];
            ie_q   <= bus_wdata[CB_IE +: 4];
         end
         if (wm_wr) wmark_q <= wm_clamped;
      end
   end

   dsf_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst_hit),
      .hw_trig (hw_trig),
      .sw_req  (sw_req),
      .sel_sw  (tsel_q),
      .trig_o  (trig)
   );

   dsf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst_hit),
      .fifo_clr (fifo_clr),
      .mode     (mode_q),
      .wr_en    (data_wr),
      .wdata    (bus_wdata[DW-1:0]),
      .trig     (trig),
      .dac_code (dac_code),
      .rd_ptr   (rd_ptr),
      .wr_ptr   (wr_ptr),
      .count    (count),
      .ovf_evt  (ovf_evt),
      .udf_evt  (udf_evt)
   );

   dsf_flags #(.DEPTH(DEPTH)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst_hit),
      .ovf_evt (ovf_evt),
      .udf_evt (udf_evt),
      .clr_ovf (ctrl_wr & bus_wdata[CB_OVF]),
      .clr_udf (ctrl_wr & bus_wdata[CB_UDF]),
      .count   (count),
      .wmark   (wmark_q),
      .ie      (ie_q),
      .dma_sel (dma_q),
      .ovf_f   (ovf_f),
      .udf_f   (udf_f),
      .wm_f    (wm_f),
      .ne_f    (ne_f),
      .full_f  (full_f),
      .irq     (irq),
      .dma_req (dma_req)
   );

   // pointer fields widen to the fixed 8-bit register slots
   generate
      if (AW == 8) begin : g_ptr_full
         assign rd_field = rd_ptr;
         assign wr_field = wr_ptr;
      end else begin : g_ptr_pad
         assign rd_field = {{(8 - AW){1'b0}}, rd_ptr};
         assign wr_field = {{(8 - AW){1'b0}}, wr_ptr};
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[CB_MODE +: 2]  = mode_q;
            bus_rdata[CB_TSEL]       = tsel_q;
            bus_rdata[CB_CONV]       = conv_q;
            bus_rdata[CB_DMA]        = dma_q;
            bus_rdata[CB_IE +: 4]    = ie_q;
            bus_rdata[CB_OVF]        = ovf_f;
            bus_rdata[CB_UDF]        = udf_f;
            bus_rdata[CB_WM]         = wm_f;
            bus_rdata[CB_NE]         = ne_f;
            bus_rdata[CB_FULL]       = full_f;
            bus_rdata[CB_DCODE +: 3] = DCODE;
         end
         A_PTR:   bus_rdata[15:0]    = {wr_field, rd_field};
         A_WMARK: bus_rdata[CW-1:0]  = wmark_q;
         default: bus_rdata          = '0;
      endcase
   end

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 12,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [1:0]    bus_addr,
   input logic [31:0]   bus_wdata,
   input logic          irq,
   input logic          dma_req,
   input logic [DW-1:0] dac_code,
   input logic [CW-1:0] count,
   input logic [AW-1:0] rd_ptr,
   input logic [AW-1:0] wr_ptr,
   input logic          ovf_f,
   input logic          trig,
   input logic [1:0]    mode_q,
   input logic          srst_hit,
   input logic          fifo_clr,
   input logic          conv_q
);

   logic fifo_mode, data_wr, ctrl_wr;
   assign fifo_mode = (mode_q == 2'd1) || (mode_q == 2'd2);
   assign data_wr   = bus_wr && (bus_addr == 2'd1);
   assign ctrl_wr   = bus_wr && (bus_addr == 2'd0);

   a_r10_irq_dma_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && dma_req));

   a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r2_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !fifo_mode) |=> (dac_code == $past(bus_wdata[DW-1:0])));

   a_r6_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && fifo_mode && count == CW'(DEPTH)) |=> $stable(wr_ptr));

   a_r7_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_q == 2'd1 && count <= CW'(1) && !srst_hit && !fifo_clr)
      |=> ($stable(rd_ptr) && $stable(dac_code)));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_f && !(ctrl_wr && (bus_wdata[16] || bus_wdata[11]))) |=> ovf_f);

   a_r11_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_q && ctrl_wr && bus_wdata[10] && !bus_wdata[11]) |=> $stable(wr_ptr));

endmodule

bind dac_sample_fifo dsf_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .dma_req   (dma_req),
   .dac_code  (dac_code),
   .count     (count),
   .rd_ptr    (rd_ptr),
   .wr_ptr    (wr_ptr),
   .ovf_f     (ovf_f),
   .trig      (trig),
   .mode_q    (mode_q),
   .srst_hit  (srst_hit),
   .fifo_clr  (fifo_clr),
   .conv_q    (conv_q)
);

// File: tb/dac_sample_fifo_bench.sv
module dac_sample_fifo_bench;

   localparam int DEPTH = 4;
   localparam int DW    = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          hw_trig = 1'b0;
   logic [DW-1:0] dac_code;
   logic          irq, dma_req;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] prev_code = '0;

   always #2.5 clk = ~clk;

   dac_sample_fifo #(.DEPTH(DEPTH), .DW(DW), .SYNC_STAGES(2)) u_dac_sample_fifo (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
      .dac_code(dac_code), .irq(irq), .dma_req(dma_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // driver side of the scoreboard: predicted next output value
   task automatic expect_out(input logic [DW-1:0] v);
      exp_q.push_back(v);
   endtask

   task automatic hw_pulse();
      @(negedge clk); hw_trig = 1'b1;
      repeat (3) @(negedge clk);
      hw_trig = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   // monitor side: each change of dac_code pops one prediction
   always @(negedge clk) begin
      if (rst_n && dac_code !== prev_code) begin
         if (exp_q.size() == 0) begin
            check("R2/R3/R4 unexpected output change", 32'(dac_code), 32'(prev_code));
         end else begin
            check("R2/R3/R4 output sequence", 32'(dac_code), 32'(exp_q.pop_front()));
         end
         prev_code = dac_code;
      end
   end

   initial begin
      #500000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, r); check("R1 ctrl after reset", r, 32'h0100_0000);
      rd(2'd2, r); check("R1 pointers after reset", r, 32'h0);
      rd(2'd3, r); check("R1 watermark after reset", r, 32'h0);
      check("R1 dac_code after reset", 32'(dac_code), 32'h0);
      check("R1 irq after reset", 32'(irq), 32'h0);

      // R2 bypass
      expect_out(12'h123); wr(2'd1, 32'h123);
      check("R2 bypass write", 32'(dac_code), 32'h123);
      expect_out(12'hABC); wr(2'd1, 32'hABC);

      // R3 normal mode, software trigger
      wr(2'd0, 32'h5);
      wr(2'd1, 32'h101); wr(2'd1, 32'h202); wr(2'd1, 32'h303);
      rd(2'd2, r); check("R13 R3 write pointer advanced", r, 32'h0300);
      expect_out(12'h202); wr(2'd0, 32'h205);
      expect_out(12'h303); wr(2'd0, 32'h205);
      @(negedge clk);
      rd(2'd0, r); check("R9 nearly-empty flag", (r >> 19) & 1, 32'h1);
      rd(2'd2, r); check("R13 R3 read pointer", r, 32'h0302);

      // R7 underflow
      wr(2'd0, 32'h205); @(negedge clk);
      rd(2'd2, r); check("R7 read pointer held", r, 32'h0302);
      check("R7 output held", 32'(dac_code), 32'h303);
      rd(2'd0, r); check("R7 underflow flag", (r >> 17) & 1, 32'h1);
      wr(2'd0, 32'h5);
      rd(2'd0, r); check("R8 write 0 keeps flag", (r >> 17) & 1, 32'h1);
      wr(2'd0, 32'h20005);
      rd(2'd0, r); check("R8 write 1 clears flag", (r >> 17) & 1, 32'h0);

      // R6 overflow
      wr(2'd1, 32'h404); wr(2'd1, 32'h505); wr(2'd1, 32'h606);
      rd(2'd0, r); check("R9 full flag", (r >> 20) & 1, 32'h1);
      wr(2'd1, 32'h777);
      rd(2'd0, r); check("R6 overflow flag", (r >> 16) & 1, 32'h1);
      rd(2'd2, r); check("R6 write pointer unchanged", r, 32'h0202);

      // R10 interrupt vs DMA
      wr(2'd0, 32'h105);
      check("R10 irq on full", 32'(irq), 32'h1);
      check("R10 dma low", 32'(dma_req), 32'h0);
      wr(2'd0, 32'h115);
      check("R10 irq masked by DMA", 32'(irq), 32'h0);
      check("R10 dma request", 32'(dma_req), 32'h1);
      wr(2'd0, 32'h5);
      check("R10 requests idle", 32'({irq, dma_req}), 32'h0);

      // R4 swing replay
      wr(2'd0, 32'h6);
      expect_out(12'h404); wr(2'd0, 32'h206);
      expect_out(12'h505); wr(2'd0, 32'h206);
      expect_out(12'h606); wr(2'd0, 32'h206);
      expect_out(12'h505); wr(2'd0, 32'h206);
      expect_out(12'h404); wr(2'd0, 32'h206);
      expect_out(12'h303); wr(2'd0, 32'h206);
      expect_out(12'h404); wr(2'd0, 32'h206);
      @(negedge clk);
      rd(2'd2, r); check("R4 read pointer after swing", r, 32'h0203);

      // R9 watermark
      wr(2'd3, 32'h9);
      rd(2'd3, r); check("R9 watermark clamp", r, 32'h4);
      rd(2'd0, r); check("R9 watermark flag set", (r >> 18) & 1, 32'h1);
      wr(2'd3, 32'h2);
      rd(2'd0, r); check("R9 watermark flag clear", (r >> 18) & 1, 32'h0);

      // R11 FIFO clear gating
      wr(2'd0, 32'hE); wr(2'd0, 32'h40E);
      rd(2'd2, r); check("R11 clear ignored while enabled", r, 32'h0203);
      wr(2'd0, 32'h6); wr(2'd0, 32'h406);
      rd(2'd2, r); check("R11 clear while disabled", r, 32'h0);
      rd(2'd0, r); check("R11 full flag after clear", (r >> 20) & 1, 32'h0);

      // R5 hardware trigger and selection
      wr(2'd0, 32'h1);
      wr(2'd1, 32'h111); wr(2'd1, 32'h222); wr(2'd1, 32'h333);
      expect_out(12'h222); hw_pulse();
      rd(2'd2, r); check("R5 one step per pin pulse", r, 32'h0301);
      wr(2'd0, 32'h201); repeat (3) @(negedge clk);
      rd(2'd2, r); check("R5 software bit ignored on pin select", r, 32'h0301);
      wr(2'd0, 32'h5); hw_pulse();
      rd(2'd2, r); check("R5 pin ignored on software select", r, 32'h0301);

      // R12 soft reset
      wr(2'd3, 32'h3);
      expect_out(12'h000); wr(2'd0, 32'h800);
      rd(2'd0, r); check("R12 ctrl after soft reset", r, 32'h0100_0000);
      rd(2'd2, r); check("R12 pointers after soft reset", r, 32'h0);
      rd(2'd3, r); check("R12 watermark after soft reset", r, 32'h0);
      check("R12 output after soft reset", 32'(dac_code), 32'h0);

      repeat (3) @(negedge clk);
      check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule